// File: doc/BRIEF.md
# Asynchronous Serial Transceiver with Byte-Loaded Baud Divisor

This block is a full-duplex asynchronous serial port. It sends and receives 8-bit characters with one start bit, no parity and one stop bit. A single baud counter sets the bit rate for both directions. The counter runs from a 16-bit divisor that is written one byte at a time, through a high-byte strobe and a low-byte strobe that share one write-data bus. Each bit lasts 8 baud ticks. The receiver uses those ticks to oversample the line, and the transmitter uses them to time its shift register.

Software loads a character into a one-deep transmit holding buffer. When the transmitter is enabled and its shift register is idle, the buffer moves into the shift register and is sent out least significant bit first. The receiver watches for a falling edge on the synchronised input and confirms the start bit half a bit later. It then samples each bit at its centre and, once the stop position is reached, places the character in a receive holding buffer. A ready flag and an interrupt request go high at that point. A framing flag and an overrun flag describe the most recent character.

Top module: `uart_core`

## Requirements
- R1: The bit period on the serial lines is 8 × (divisor + 1) clock cycles, and the divisor resets to 0.
- R2: `div_hi_we` loads `wr_data` into divisor bits 15:8, and `div_lo_we` loads `wr_data` into divisor bits 7:0.
- R3: A frame is a 0 start bit, then 8 data bits least significant bit first, then a 1 stop bit. The same format is used to transmit on `tx_o` and to receive on `rx_i`.
- R4: A character is received only while `rx_en` is 1. Clearing `rx_en` abandons any character in progress, and the flags and `rx_data` stay as they were.
- R5: When a character completes, `rx_data` takes its value and `rx_ready` and `irq` both become 1.
- R6: A one-cycle `rxbuf_re` pulse clears `rx_ready` and `irq`.
- R7: `txbuf_we` stores `wr_data` and drives `tx_ready` to 0 in the next cycle. While `tx_en` is 0 no frame starts, and `tx_o` stays at 1.
- R8: `tx_ready` returns to 1 when the buffered byte moves into the shift register. This happens only when `tx_en` is 1 and no frame is being sent, so a byte written during a frame waits until that frame ends.
- R9: `framing_err` is 1 after a character whose stop bit was sampled as 0, and 0 after a character whose stop bit was sampled as 1.
- R10: `overrun` is 1 after a character that completed while `rx_ready` was still 1. In that case the new byte replaces the old one in `rx_data`. `overrun` is 0 after a character that arrived into an empty buffer.
- R11: After reset, `tx_o` = 1, `tx_ready` = 1, and `rx_ready`, `irq`, `framing_err` and `overrun` are all 0.
- R12: The start bit is confirmed half a bit after the falling edge. A low pulse shorter than that produces no character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_data | input | 8 | Write data for the divisor bytes and the transmit buffer |
| div_hi_we | input | 1 | Load the divisor high byte |
| div_lo_we | input | 1 | Load the divisor low byte |
| txbuf_we | input | 1 | Load the transmit holding buffer |
| rxbuf_re | input | 1 | Receive buffer read strobe, clears the ready flag |
| tx_en | input | 1 | Transmitter enable |
| rx_en | input | 1 | Receiver enable |
| rx_i | input | 1 | Serial receive line |
| tx_o | output | 1 | Serial transmit line |
| rx_data | output | 8 | Receive holding buffer |
| tx_ready | output | 1 | Transmit buffer empty |
| rx_ready | output | 1 | Receive buffer holds an unread character |
| framing_err | output | 1 | The last character had a bad stop bit |
| overrun | output | 1 | The last character overwrote an unread one |
| irq | output | 1 | Receive interrupt request |

## Verification
A baud counter that wraps at the wrong count changes the spacing of edges inside a transmitted frame from the very first bit. The check that times one data bit on `tx_o` exposes it within one bit period. A receiver state machine that samples at the wrong phase, or that counts the wrong number of bits, shows up as a wrong `rx_data` value or a wrong `framing_err` value at the end of that same character. A transmit buffer flag that does not track the handoff to the shift register shows within a cycle or two of a write, either as `tx_ready` stuck at 0 or as a start bit appearing while `tx_en` is 0.

// File: rtl/uart_core.sv
module uart_core #(
  parameter int          OSR      = 8,
  parameter logic [15:0] DIV_INIT = 16'd0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] wr_data,
  input  logic       div_hi_we,
  input  logic       div_lo_we,
  input  logic       txbuf_we,
  input  logic       rxbuf_re,
  input  logic       tx_en,
  input  logic       rx_en,
  input  logic       rx_i,
  output logic       tx_o,
  output logic [7:0] rx_data,
  output logic       tx_ready,
  output logic       rx_ready,
  output logic       framing_err,
  output logic       overrun,
  output logic       irq
);
  localparam int PH_W = $clog2(OSR);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(OSR - 1);
  localparam logic [PH_W-1:0] PH_MID  = PH_W'(OSR / 2 - 1);

  // baud tick
  logic [15:0] div_q, bcnt_q;
  logic tick;
  assign tick = (bcnt_q >= div_q);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      div_q  <= DIV_INIT;
      bcnt_q <= '0;
    end else begin
      if (div_hi_we) div_q[15:8] <= wr_data;
      if (div_lo_we) div_q[7:0]  <= wr_data;
      bcnt_q <= tick ? '0 : bcnt_q + 16'd1;
    end

  // transmit path
  logic [7:0]      tbuf_q;
  logic            tfull_q, tbusy_q;
  logic [9:0]      tsh_q;
  logic [PH_W-1:0] tph_q;
  logic [3:0]      tbit_q;
  logic            tload, tstep;

  assign tload = tx_en && tfull_q && !tbusy_q;
  assign tstep = tbusy_q && tick && (tph_q == PH_LAST);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tbuf_q  <= '0;
      tfull_q <= 1'b0;
      tbusy_q <= 1'b0;
      tsh_q   <= '1;
      tph_q   <= '0;
      tbit_q  <= '0;
    end else begin
      if (tload) begin
        tsh_q   <= {1'b1, tbuf_q, 1'b0};
        tbusy_q <= 1'b1;
        tph_q   <= '0;
        tbit_q  <= '0;
        tfull_q <= 1'b0;
      end else if (tbusy_q && tick) begin
        tph_q <= tstep ? '0 : tph_q + 1'b1;
        if (tstep) begin
          tsh_q  <= {1'b1, tsh_q[9:1]};
          tbit_q <= tbit_q + 4'd1;
          if (tbit_q == 4'd9) tbusy_q <= 1'b0;
        end
      end
      if (txbuf_we) begin
        tbuf_q  <= wr_data;
        tfull_q <= 1'b1;
      end
    end

  assign tx_o     = tbusy_q ? tsh_q[0] : 1'b1;
  assign tx_ready = !tfull_q;

  // receive path
  typedef enum logic [1:0] {R_IDLE, R_START, R_DATA, R_STOP} rx_state_e;
  rx_state_e       rst_q;
  logic [2:0]      rsync_q;
  logic [PH_W-1:0] rph_q;
  logic [2:0]      rbit_q;
  logic [7:0]      rsh_q;
  logic            rx_s, rx_prev, rx_done;

  assign rx_s    = rsync_q[1];
  assign rx_prev = rsync_q[2];
  assign rx_done = rx_en && (rst_q == R_STOP) && tick && (rph_q == PH_LAST);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rsync_q <= '1;
      rst_q   <= R_IDLE;
      rph_q   <= '0;
      rbit_q  <= '0;
      rsh_q   <= '0;
    end else begin
      rsync_q <= {rsync_q[1:0], rx_i};
      if (!rx_en) rst_q <= R_IDLE;
      else case (rst_q)
        R_IDLE:
          if (!rx_s && rx_prev) begin
            rst_q <= R_START;
            rph_q <= '0;
          end
        R_START:
          if (tick) begin
            if (rph_q == PH_MID) begin
              rph_q  <= '0;
              rbit_q <= '0;
              rst_q  <= rx_s ? R_IDLE : R_DATA;
            end else rph_q <= rph_q + 1'b1;
          end
        R_DATA:
          if (tick) begin
            if (rph_q == PH_LAST) begin
              rph_q  <= '0;
              rsh_q  <= {rx_s, rsh_q[7:1]};
              rbit_q <= rbit_q + 3'd1;
              if (rbit_q == 3'd7) rst_q <= R_STOP;
            end else rph_q <= rph_q + 1'b1;
          end
        R_STOP:
          if (tick) begin
            if (rph_q == PH_LAST) rst_q <= R_IDLE;
            else rph_q <= rph_q + 1'b1;
          end
        default: rst_q <= R_IDLE;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_data     <= '0;
      rx_ready    <= 1'b0;
      framing_err <= 1'b0;
      overrun     <= 1'b0;
    end else if (rx_done) begin
      rx_data     <= rsh_q;
      rx_ready    <= 1'b1;
      framing_err <= !rx_s;
      overrun     <= rx_ready && !rxbuf_re;
    end else if (rxbuf_re) begin
      rx_ready <= 1'b0;
    end

  assign irq = rx_ready;
endmodule

module uart_core_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rx_en,
  input logic        tx_en,
  input logic        txbuf_we,
  input logic        rxbuf_re,
  input logic        rx_ready,
  input logic        tx_ready,
  input logic        tx_o,
  input logic        tbusy,
  input logic        tick,
  input logic [15:0] div_q,
  input logic        rx_done
);
  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div_q != 16'd0) |=> !tick);  // R1
  AST_RX_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ready) |-> $past(rx_en));  // R4
  AST_RX_DONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> rx_ready);  // R5
  AST_RX_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rxbuf_re && !rx_done) |=> !rx_ready);  // R6
  AST_TX_WRITE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    txbuf_we |=> !tx_ready);  // R7
  AST_TX_START_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(tx_o) && !$past(tbusy)) |-> $past(tx_en));  // R7
  AST_TX_LOAD_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_ready) |-> $past(tx_en));  // R8
endmodule

bind uart_core uart_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .tx_en(tx_en),
  .txbuf_we(txbuf_we), .rxbuf_re(rxbuf_re), .rx_ready(rx_ready),
  .tx_ready(tx_ready), .tx_o(tx_o), .tbusy(tbusy_q), .tick(tick),
  .div_q(div_q), .rx_done(rx_done)
);

// File: tb/uart_core_bench.sv
module uart_core_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] wr_data = '0;
  logic div_hi_we = 0, div_lo_we = 0, txbuf_we = 0, rxbuf_re = 0;
  logic tx_en = 0, rx_en = 0, rx_i = 1'b1;
  logic tx_o, tx_ready, rx_ready, framing_err, overrun, irq;
  logic [7:0] rx_data;

  int checks = 0;
  int fails = 0;
  int bitclk = 8;

  always #10 clk = ~clk;

  uart_core u_uart_core (
    .clk(clk), .rst_n(rst_n), .wr_data(wr_data),
    .div_hi_we(div_hi_we), .div_lo_we(div_lo_we),
    .txbuf_we(txbuf_we), .rxbuf_re(rxbuf_re),
    .tx_en(tx_en), .rx_en(rx_en), .rx_i(rx_i), .tx_o(tx_o),
    .rx_data(rx_data), .tx_ready(tx_ready), .rx_ready(rx_ready),
    .framing_err(framing_err), .overrun(overrun), .irq(irq)
  );

  // bit 8 = stop bit level, bits 7:0 = character
  localparam logic [8:0] VEC [0:5] = '{9'h1A5, 9'h100, 9'h1FF, 9'h13C, 9'h0C3, 9'h181};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_div(input logic [15:0] d);
    @(negedge clk) wr_data = d[15:8]; div_hi_we = 1;
    @(negedge clk) div_hi_we = 0; wr_data = d[7:0]; div_lo_we = 1;
    @(negedge clk) div_lo_we = 0;
    bitclk = 8 * (int'(d) + 1);
  endtask

  task automatic send_rx(input logic [7:0] d, input bit stop_lvl);
    @(negedge clk) rx_i = 1'b0;
    repeat (bitclk) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx_i = d[i];
      repeat (bitclk) @(negedge clk);
    end
    rx_i = stop_lvl;
    repeat (bitclk) @(negedge clk);
    rx_i = 1'b1;
    repeat (bitclk) @(negedge clk);
  endtask

  task automatic read_rx();
    rxbuf_re = 1;
    @(negedge clk) rxbuf_re = 0;
  endtask

  task automatic write_tx(input logic [7:0] d);
    wr_data = d; txbuf_we = 1;
    @(negedge clk) txbuf_we = 0;
  endtask

  task automatic cap_tx(output logic [7:0] d, output logic stopb);
    while (tx_o !== 1'b0) @(negedge clk);
    repeat (bitclk / 2) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      repeat (bitclk) @(negedge clk);
      d[i] = tx_o;
    end
    repeat (bitclk) @(negedge clk);
    stopb = tx_o;
  endtask

  task automatic measure(output int n);
    write_tx(8'h55);
    while (tx_o !== 1'b0) @(negedge clk);
    while (tx_o !== 1'b1) @(negedge clk);
    n = 0;
    while (tx_o === 1'b1) begin
      @(negedge clk);
      n++;
    end
    repeat (9 * bitclk) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d, d2;
    logic s;
    int n;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tx_o == 1, "R11 tx_o", tx_o, 1);
    chk(tx_ready == 1, "R11 tx_ready", tx_ready, 1);
    chk(rx_ready == 0, "R11 rx_ready", rx_ready, 0);
    chk(irq == 0, "R11 irq", irq, 0);
    chk(framing_err == 0 && overrun == 0, "R11 error flags", {framing_err, overrun}, 0);

    tx_en = 1; rx_en = 1;
    measure(n);
    chk(n == 8, "R1 default divisor bit period", n, 8);
    set_div(16'd3);
    measure(n);
    chk(n == 32, "R1 divisor 3 bit period", n, 32);
    set_div(16'h0102);
    measure(n);
    chk(n == 2072, "R2 high and low byte divisor", n, 2072);
    set_div(16'd1);

    foreach (VEC[k]) begin
      send_rx(VEC[k][7:0], VEC[k][8]);
      chk(rx_ready == 1, "R5 rx_ready", rx_ready, 1);
      chk(irq == 1, "R5 irq", irq, 1);
      chk(rx_data == VEC[k][7:0], "R3 rx data", rx_data, VEC[k][7:0]);
      chk(framing_err == !VEC[k][8], "R9 framing", framing_err, !VEC[k][8]);
      read_rx();
      chk(rx_ready == 0 && irq == 0, "R6 read clears", rx_ready, 0);
      write_tx(VEC[k][7:0]);
      cap_tx(d, s);
      chk(d == VEC[k][7:0], "R3 tx data", d, VEC[k][7:0]);
      chk(s == 1, "R3 tx stop", s, 1);
    end

    send_rx(8'h3A, 1);
    send_rx(8'hC5, 1);
    chk(overrun == 1, "R10 overrun set", overrun, 1);
    chk(rx_data == 8'hC5, "R10 overwrite", rx_data, 8'hC5);
    read_rx();
    send_rx(8'h6E, 1);
    chk(overrun == 0, "R10 overrun clear", overrun, 0);
    chk(rx_data == 8'h6E, "R10 data after", rx_data, 8'h6E);
    read_rx();

    rx_en = 0;
    send_rx(8'h5A, 1);
    chk(rx_ready == 0, "R4 disabled no ready", rx_ready, 0);
    chk(rx_data == 8'h6E, "R4 disabled data kept", rx_data, 8'h6E);
    rx_en = 1;
    @(negedge clk) rx_i = 0;
    repeat (bitclk * 3) @(negedge clk);
    rx_en = 0;
    @(negedge clk) rx_i = 1;
    repeat (bitclk * 8) @(negedge clk);
    rx_en = 1;
    repeat (bitclk * 2) @(negedge clk);
    chk(rx_ready == 0, "R4 abort mid char", rx_ready, 0);

    rx_i = 0;
    repeat (3) @(negedge clk);
    rx_i = 1;
    repeat (2 * bitclk) @(negedge clk);
    chk(rx_ready == 0, "R12 glitch ignored", rx_ready, 0);
    send_rx(8'h96, 1);
    chk(rx_ready == 1 && rx_data == 8'h96, "R12 frame after glitch", rx_data, 8'h96);
    read_rx();

    tx_en = 0;
    write_tx(8'hC4);
    n = 0;
    repeat (5 * bitclk) begin
      @(negedge clk);
      if (!tx_o) n++;
    end
    chk(n == 0, "R7 tx_o held high while disabled", n, 0);
    chk(tx_ready == 0, "R7 tx_ready low after write", tx_ready, 0);
    tx_en = 1;
    cap_tx(d, s);
    chk(d == 8'hC4, "R8 byte sent after enable", d, 8'hC4);
    chk(tx_ready == 1, "R8 tx_ready after load", tx_ready, 1);
    repeat (bitclk) @(negedge clk);

    write_tx(8'h11);
    chk(tx_ready == 0, "R7 tx_ready next cycle", tx_ready, 0);
    repeat (2) @(negedge clk);
    write_tx(8'h22);
    cap_tx(d, s);
    chk(tx_ready == 0, "R8 second byte waits", tx_ready, 0);
    cap_tx(d2, s);
    chk(d == 8'h11 && d2 == 8'h22, "R8 back to back order", {d, d2}, 16'h1122);
    chk(tx_ready == 1, "R8 ready after second load", tx_ready, 1);
    repeat (2 * bitclk) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule